// File: doc/BRIEF.md
# Sequence-Unlocked Timing Register Front End

This block sits between a host-side register bus and the drive task-file of a disk-interface controller. It normally passes every access through to the drive side untouched. Its one purpose is to hide a small set of controller timing registers behind the same command-block offsets, so that software cannot reach them by accident.

A fixed access pattern switches the block into configuration mode: two back-to-back halfword reads at offset 1, then a byte write of 0x03 to offset 2. In that mode the offsets reach the timing registers and nothing goes to the drive. A device-select field in the miscellaneous register points at one of two banks of read-timing, write-timing and address-setup values. Later timing writes land in that bank. A commit write to the control register copies both staged banks to the timing outputs that the protocol engine uses. A relock write returns the block to pass-through mode.

Top module: `hidden_timing_regs`

## Requirements
- R1: After reset the block is locked (cfg_mode = 0) and device 0 is selected. Every staged and active read-timing and write-timing value is 0xFF, and every address-setup value is 0xF.
- R2: While locked, bus_rd, bus_wr, bus_addr, bus_wide and bus_wdata appear unchanged on the drive-side outputs in the same cycle, and bus_rdata equals drv_rdata. No timing value changes.
- R3: Two consecutive accesses that are halfword reads (bus_wide = 1) at offset 1, followed by a byte write (bus_wide = 0) of 0x03 in bits 7:0 at offset 2, set cfg_mode from the next cycle. A third qualifying read before the write still counts as two consecutive reads. Cycles with no strobe do not disturb the sequence. The unlocking write itself is still forwarded.
- R4: Any other access between the first read and the unlocking write returns the detector to idle, and the full sequence is then needed again. Examples are a byte read at offset 1, a write, a read at another offset, or a write of a value other than 0x03.
- R5: While cfg_mode = 1, drv_rd and drv_wr stay low, and bus_rdata comes from the register file, zero-extended from 8 bits.
- R6: A configuration write at offset 6 sets the device select to bit 0 and stores bits 7:4 as the address-setup value of the newly selected device. A read at offset 6 returns setup<<4 | select.
- R7: A configuration write at offset 0 (read timing) or offset 1 (write timing) updates the staged value of the selected device only. A read at the same offset returns the staged value of the selected device.
- R8: The timing outputs change only when 0x85 is written to offset 3 in configuration mode. From the next cycle they then equal all staged values. Any other value written there has no effect.
- R9: A configuration read at offset 5 returns strap_clk25 in bit 0 (0 = 33 MHz bus clock, 1 = 25 MHz) with all other bits zero, and writes there are ignored. Reads at offsets 2, 3 and 4 return zero.
- R10: A configuration write of 0x83 to offset 2 clears cfg_mode from the next cycle and is not forwarded. Other values written there are ignored. Staged values survive the relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Command-block offset |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wide | input | 1 | 1 = halfword access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| strap_clk25 | input | 1 | Bus-clock strap, 1 = 25 MHz |
| drv_addr | output | 3 | Forwarded offset |
| drv_rd | output | 1 | Forwarded read strobe |
| drv_wr | output | 1 | Forwarded write strobe |
| drv_wide | output | 1 | Forwarded access width |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Drive-side read data |
| cfg_mode | output | 1 | 1 = configuration mode |
| rd_tim_o | output | 16 | Active read timing, device d at bits 8d+7:8d |
| wr_tim_o | output | 16 | Active write timing, device d at bits 8d+7:8d |
| setup_o | output | 8 | Active address setup, device d at bits 4d+3:4d |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, and that each high cycle is exactly one access. They also assume that only the low byte of write data matters in configuration mode. The bench changes inputs only on the falling edge and issues at most one strobe per cycle. It moves strap_clk25 only between accesses. The random phase draws offsets and key values (0x03, 0x83, 0x85) with a bias, so that unlock, relock and commit paths are hit often without ever asserting both strobes at once.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
    localparam int OFF_RDTIM = 0;
    localparam int OFF_WRTIM = 1;
    localparam int OFF_LOCK  = 2;
    localparam int OFF_CTRL  = 3;
    localparam int OFF_STRAP = 5;
    localparam int OFF_MISC  = 6;

    localparam logic [7:0] KEY_UNLOCK = 8'h03;
    localparam logic [7:0] KEY_RELOCK = 8'h83;
    localparam logic [7:0] KEY_COMMIT = 8'h85;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;
endpackage

// File: rtl/tmg_unlock_seq.sv
module tmg_unlock_seq
    import tmg_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          wide,
    input  logic [7:0]    wbyte,
    output logic          cfg_mode
);
    typedef struct packed {
        seq_e seq;
        logic cfg;
    } st_t;

    st_t st_d, st_q;

    logic qual_rd, key_wr, relock_wr;

    always_comb begin
        qual_rd   = rd && wide && (addr == AW'(OFF_WRTIM));
        key_wr    = wr && !wide && (addr == AW'(OFF_LOCK)) && (wbyte == KEY_UNLOCK);
        relock_wr = wr && (addr == AW'(OFF_LOCK)) && (wbyte == KEY_RELOCK);
        st_d      = st_q;
        if (!st_q.cfg) begin
            if (qual_rd) begin
                st_d.seq = (st_q.seq == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
            end else if (key_wr && st_q.seq == SEQ_TWO) begin
                st_d.cfg = 1'b1;
                st_d.seq = SEQ_IDLE;
            end else if (rd || wr) begin
                st_d.seq = SEQ_IDLE;
            end
        end else if (relock_wr) begin
            st_d.cfg = 1'b0;
            st_d.seq = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seq: SEQ_IDLE, cfg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_mode = st_q.cfg;

    AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(wr && !wide && addr == AW'(OFF_LOCK) && wbyte == KEY_UNLOCK)); // R3

    AST_RELOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_mode) |-> $past(wr && addr == AW'(OFF_LOCK) && wbyte == KEY_RELOCK)); // R10
endmodule

// File: rtl/tmg_bank_file.sv
module tmg_bank_file
    import tmg_pkg::*;
#(
    parameter int AW   = 3,
    parameter int NDEV = 2,
    parameter int TW   = 8,
    parameter int SW   = 4,
    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wbyte,
    output logic [SELW-1:0]   sel_o,
    output logic [TW-1:0]     rd_sel_o,
    output logic [TW-1:0]     wr_sel_o,
    output logic [SW-1:0]     su_sel_o,
    output logic [NDEV*TW-1:0] act_rd_o,
    output logic [NDEV*TW-1:0] act_wr_o,
    output logic [NDEV*SW-1:0] act_su_o
);
    localparam logic [TW-1:0] SLOW_TIM = {TW{1'b1}};
    localparam logic [SW-1:0] SLOW_SU  = {SW{1'b1}};

    typedef struct packed {
        logic [SELW-1:0]         sel;
        logic [NDEV-1:0][TW-1:0] srd;
        logic [NDEV-1:0][TW-1:0] swr;
        logic [NDEV-1:0][SW-1:0] ssu;
        logic [NDEV-1:0][TW-1:0] ard;
        logic [NDEV-1:0][TW-1:0] awr;
        logic [NDEV-1:0][SW-1:0] asu;
    } st_t;

    st_t st_d, st_q;
    logic [SELW-1:0] new_sel;

    always_comb begin
        st_d    = st_q;
        new_sel = wbyte[SELW-1:0];
        if (cfg_wr) begin
            if (addr == AW'(OFF_RDTIM)) begin
                for (int d = 0; d < NDEV; d++)
                    if (st_q.sel == SELW'(d)) st_d.srd[d] = wbyte[TW-1:0];
            end else if (addr == AW'(OFF_WRTIM)) begin
                for (int d = 0; d < NDEV; d++)
                    if (st_q.sel == SELW'(d)) st_d.swr[d] = wbyte[TW-1:0];
            end else if (addr == AW'(OFF_MISC)) begin
                for (int d = 0; d < NDEV; d++)
                    if (new_sel == SELW'(d)) begin
                        st_d.sel    = new_sel;
                        st_d.ssu[d] = wbyte[7 -: SW];
                    end
            end else if (addr == AW'(OFF_CTRL) && wbyte == KEY_COMMIT) begin
                st_d.ard = st_q.srd;
                st_d.awr = st_q.swr;
                st_d.asu = st_q.ssu;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= '0;
            st_q.srd <= {NDEV{SLOW_TIM}};
            st_q.swr <= {NDEV{SLOW_TIM}};
            st_q.ssu <= {NDEV{SLOW_SU}};
            st_q.ard <= {NDEV{SLOW_TIM}};
            st_q.awr <= {NDEV{SLOW_TIM}};
            st_q.asu <= {NDEV{SLOW_SU}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_sel_o = '0;
        wr_sel_o = '0;
        su_sel_o = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (st_q.sel == SELW'(d)) begin
                rd_sel_o = st_q.srd[d];
                wr_sel_o = st_q.swr[d];
                su_sel_o = st_q.ssu[d];
            end
        end
    end

    assign sel_o = st_q.sel;

    for (genvar g = 0; g < NDEV; g++) begin : g_out
        assign act_rd_o[g*TW +: TW] = st_q.ard[g];
        assign act_wr_o[g*TW +: TW] = st_q.awr[g];
        assign act_su_o[g*SW +: SW] = st_q.asu[g];
    end

    AST_MISC_SETS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && addr == AW'(OFF_MISC) && int'(wbyte[SELW-1:0]) < NDEV)
        |=> (sel_o == $past(wbyte[SELW-1:0]))); // R6
endmodule

// File: rtl/hidden_timing_regs.sv
module hidden_timing_regs
    import tmg_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DW   = 16,
    parameter int NDEV = 2,
    parameter int TW   = 8,
    parameter int SW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               strap_clk25,
    output logic [AW-1:0]      drv_addr,
    output logic               drv_rd,
    output logic               drv_wr,
    output logic               drv_wide,
    output logic [DW-1:0]      drv_wdata,
    input  logic [DW-1:0]      drv_rdata,
    output logic               cfg_mode,
    output logic [NDEV*TW-1:0] rd_tim_o,
    output logic [NDEV*TW-1:0] wr_tim_o,
    output logic [NDEV*SW-1:0] setup_o
);
    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic [7:0]      wbyte;
    logic [SELW-1:0] sel;
    logic [TW-1:0]   rd_sel, wr_sel;
    logic [SW-1:0]   su_sel;
    logic [7:0]      cfg_byte;

    assign wbyte = bus_wdata[7:0];

    tmg_unlock_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wide     (bus_wide),
        .wbyte    (wbyte),
        .cfg_mode (cfg_mode)
    );

    tmg_bank_file #(.AW(AW), .NDEV(NDEV), .TW(TW), .SW(SW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_mode && bus_wr),
        .addr     (bus_addr),
        .wbyte    (wbyte),
        .sel_o    (sel),
        .rd_sel_o (rd_sel),
        .wr_sel_o (wr_sel),
        .su_sel_o (su_sel),
        .act_rd_o (rd_tim_o),
        .act_wr_o (wr_tim_o),
        .act_su_o (setup_o)
    );

    always_comb begin
        cfg_byte = '0;
        if (bus_addr == AW'(OFF_RDTIM)) begin
            cfg_byte[TW-1:0] = rd_sel;
        end else if (bus_addr == AW'(OFF_WRTIM)) begin
            cfg_byte[TW-1:0] = wr_sel;
        end else if (bus_addr == AW'(OFF_STRAP)) begin
            cfg_byte[0] = strap_clk25;
        end else if (bus_addr == AW'(OFF_MISC)) begin
            cfg_byte[7 -: SW]   = su_sel;
            cfg_byte[SELW-1:0]  = sel;
        end
    end

    assign drv_addr  = bus_addr;
    assign drv_wide  = bus_wide;
    assign drv_wdata = bus_wdata;
    assign drv_rd    = bus_rd && !cfg_mode;
    assign drv_wr    = bus_wr && !cfg_mode;
    assign bus_rdata = cfg_mode ? DW'(cfg_byte) : drv_rdata;

    AST_FWD_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_rd || drv_wr) |-> !cfg_mode); // R5

    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_mode && bus_wr && bus_addr == AW'(OFF_CTRL) && wbyte == KEY_COMMIT)
        |=> ($stable(rd_tim_o) && $stable(wr_tim_o) && $stable(setup_o))); // R8

    AST_NO_CFG_WHILE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && bus_rd) |-> (bus_rdata == drv_rdata)); // R2
endmodule

// File: tb/hidden_timing_regs_tb.sv
module hidden_timing_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        strap_clk25 = 1'b0;
    logic [2:0]  drv_addr;
    logic        drv_rd, drv_wr, drv_wide;
    logic [15:0] drv_wdata;
    logic [15:0] drv_rdata = '0;
    logic        cfg_mode;
    logic [15:0] rd_tim_o, wr_tim_o;
    logic [7:0]  setup_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_mode, m_seq, m_sel;
    int m_srd[2], m_swr[2], m_ssu[2], m_ard[2], m_awr[2], m_asu[2];

    always #5 clk = ~clk;

    hidden_timing_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_clk25(strap_clk25), .drv_addr(drv_addr), .drv_rd(drv_rd), .drv_wr(drv_wr),
        .drv_wide(drv_wide), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .cfg_mode(cfg_mode), .rd_tim_o(rd_tim_o), .wr_tim_o(wr_tim_o), .setup_o(setup_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_seq = 0; m_sel = 0;
        for (int d = 0; d < 2; d++) begin
            m_srd[d] = 255; m_swr[d] = 255; m_ssu[d] = 15;
            m_ard[d] = 255; m_awr[d] = 255; m_asu[d] = 15;
        end
    endtask

    function automatic int exp_cfg_read(input int a);
        case (a)
            0: return m_srd[m_sel];
            1: return m_swr[m_sel];
            5: return int'(strap_clk25);
            6: return (m_ssu[m_sel] << 4) | m_sel;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input int a, input bit rd, input bit wr, input bit wide, input int d);
        int b;
        b = d & 255;
        if (m_mode == 0) begin
            if (rd && wide && a == 1) m_seq = (m_seq == 0) ? 1 : 2;
            else if (wr && !wide && a == 2 && b == 3 && m_seq == 2) begin m_mode = 1; m_seq = 0; end
            else if (rd || wr) m_seq = 0;
        end else if (wr) begin
            case (a)
                0: m_srd[m_sel] = b;
                1: m_swr[m_sel] = b;
                2: if (b == 8'h83) m_mode = 0;
                3: if (b == 8'h85) begin
                       for (int k = 0; k < 2; k++) begin
                           m_ard[k] = m_srd[k]; m_awr[k] = m_swr[k]; m_asu[k] = m_ssu[k];
                       end
                   end
                6: begin m_sel = b & 1; m_ssu[m_sel] = (b >> 4) & 15; end
                default: ;
            endcase
        end
    endtask

    task automatic chk_regs();
        chk("R3 cfg_mode", 32'(cfg_mode), 32'(m_mode));
        chk("R8 rd_tim_o", 32'(rd_tim_o), 32'((m_ard[1] << 8) | m_ard[0]));
        chk("R8 wr_tim_o", 32'(wr_tim_o), 32'((m_awr[1] << 8) | m_awr[0]));
        chk("R8 setup_o",  32'(setup_o),  32'((m_asu[1] << 4) | m_asu[0]));
    endtask

    // one bus cycle: drive at negedge, check combinational paths, then registered state
    task automatic cyc(input int a, input bit rd, input bit wr, input bit wide, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = rd; bus_wr = wr; bus_wide = wide; bus_wdata = 16'(d);
        drv_rdata = 16'($urandom);
        #1;
        if (m_mode == 0) begin
            chk("R2 drv_rd", 32'(drv_rd), 32'(rd));
            chk("R2 drv_wr", 32'(drv_wr), 32'(wr));
            if (rd || wr) begin
                chk("R2 drv_addr", 32'(drv_addr), 32'(a));
                chk("R2 drv_wide", 32'(drv_wide), 32'(wide));
            end
            if (wr) chk("R2 drv_wdata", 32'(drv_wdata), 32'(d & 16'hFFFF));
            if (rd) chk("R2 bus_rdata", 32'(bus_rdata), 32'(drv_rdata));
        end else begin
            chk("R5 drv_rd low", 32'(drv_rd), 0);
            chk("R5 drv_wr low", 32'(drv_wr), 0);
            if (rd) begin
                if (a == 0 || a == 1) chk("R7 cfg read", 32'(bus_rdata), 32'(exp_cfg_read(a)));
                else if (a == 6)      chk("R6 misc read", 32'(bus_rdata), 32'(exp_cfg_read(a)));
                else                  chk("R9 cfg read", 32'(bus_rdata), 32'(exp_cfg_read(a)));
            end
        end
        @(posedge clk);
        model_step(a, rd, wr, wide, d);
        #1;
        chk_regs();
    endtask

    task automatic do_unlock();
        cyc(1, 1, 0, 1, 0);
        cyc(1, 1, 0, 1, 0);
        cyc(2, 0, 1, 0, 3);
    endtask

    task automatic cfg_rd(input string tag, input int a, input int exp);
        cyc(a, 1, 0, 0, 0);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 cfg_mode reset", 32'(cfg_mode), 0);
        chk("R1 rd_tim reset", 32'(rd_tim_o), 32'h0000FFFF);
        chk("R1 wr_tim reset", 32'(wr_tim_o), 32'h0000FFFF);
        chk("R1 setup reset", 32'(setup_o), 32'h000000FF);

        // R2 pass-through with assorted patterns
        cyc(0, 0, 1, 1, 16'hBEEF);
        cyc(7, 1, 0, 1, 0);
        cyc(2, 0, 1, 0, 16'h0083);
        cyc(3, 0, 1, 0, 16'h0085);
        cyc(1, 1, 0, 0, 0);

        // R4 broken sequences
        cyc(1, 1, 0, 1, 0); cyc(1, 1, 0, 1, 0); cyc(2, 0, 1, 0, 4); cyc(2, 0, 1, 0, 3);
        chk("R4 wrong key", 32'(cfg_mode), 0);
        cyc(1, 1, 0, 1, 0); cyc(1, 1, 0, 0, 0); cyc(1, 1, 0, 1, 0); cyc(2, 0, 1, 0, 3);
        chk("R4 byte read breaks", 32'(cfg_mode), 0);
        cyc(1, 1, 0, 1, 0); cyc(0, 1, 0, 1, 0); cyc(1, 1, 0, 1, 0); cyc(2, 0, 1, 0, 3);
        chk("R4 other offset breaks", 32'(cfg_mode), 0);
        cyc(1, 1, 0, 1, 0); cyc(1, 1, 0, 1, 0); cyc(2, 0, 1, 1, 3); cyc(2, 0, 1, 0, 3);
        chk("R4 wide key write breaks", 32'(cfg_mode), 0);

        // R3 unlock, with a third read and an idle cycle inside
        cyc(1, 1, 0, 1, 0); cyc(0, 0, 0, 0, 0); cyc(1, 1, 0, 1, 0); cyc(1, 1, 0, 1, 0);
        cyc(2, 0, 1, 0, 3);
        chk("R3 unlocked", 32'(cfg_mode), 1);

        // R6 / R7 program both banks
        cyc(6, 0, 1, 0, 8'hA1);
        cfg_rd("R6 misc readback dev1", 6, 8'hA1);
        cyc(0, 0, 1, 0, 8'h46); cyc(1, 0, 1, 0, 8'h32);
        cfg_rd("R7 rd tim dev1", 0, 8'h46);
        cyc(6, 0, 1, 0, 8'h30);
        cfg_rd("R7 rd tim dev0 untouched", 0, 8'hFF);
        cyc(0, 0, 1, 0, 8'h59); cyc(1, 0, 1, 0, 8'h58);
        cfg_rd("R7 wr tim dev0", 1, 8'h58);
        cyc(6, 0, 1, 0, 8'hF1);
        cfg_rd("R7 wr tim dev1 kept", 1, 8'h32);

        // R8 commit behaviour
        cyc(3, 0, 1, 0, 8'h84);
        chk("R8 no commit", 32'(rd_tim_o), 32'h0000FFFF);
        cyc(3, 0, 1, 0, 8'h85);
        chk("R8 commit rd", 32'(rd_tim_o), 32'h00004659);
        chk("R8 commit setup", 32'(setup_o), 32'h000000F3);

        // R9 strap and empty offsets
        cyc(5, 0, 1, 0, 8'hFF);
        cfg_rd("R9 strap 33", 5, 0);
        strap_clk25 = 1'b1;
        cfg_rd("R9 strap 25", 5, 1);
        cfg_rd("R9 offset 4 zero", 4, 0);
        strap_clk25 = 1'b0;

        // R10 relock
        cyc(2, 0, 1, 0, 8'h80);
        chk("R10 other value ignored", 32'(cfg_mode), 1);
        cyc(2, 0, 1, 0, 8'h83);
        chk("R10 relocked", 32'(cfg_mode), 0);
        do_unlock();
        cfg_rd("R10 staging survives", 0, 8'h46);
        cyc(2, 0, 1, 1, 16'h0083);

        // random stream against the model
        for (int i = 0; i < 3000; i++) begin
            int r, a, d;
            r = $urandom % 16;
            if (r == 0) do_unlock();
            else begin
                a = $urandom % 8;
                case ($urandom % 4)
                    0: d = 3;
                    1: d = 8'h83;
                    2: d = 8'h85;
                    default: d = $urandom % 65536;
                endcase
                case ($urandom % 3)
                    0: cyc(a, 1, 0, $urandom % 2, 0);
                    1: cyc(a, 0, 1, $urandom % 2, d);
                    default: cyc(a, 0, 0, 0, 0);
                endcase
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule